// File: doc/BRIEF.md
# Memory-Mapped Down-Counting Event Timer

This block is a single-channel timer that sits on a simple APB-style register bus. Software writes a 64-bit reload value as two 32-bit words. It then sets the enable bit. On that edge of the enable bit the 64-bit counter takes the reload value, and it then counts down by one on every bus clock. The counter runs in one of two modes. In the periodic mode it reloads by itself each time it passes zero. In the one-shot mode it stops at zero.

Each zero event sets a sticky pending flag. Software clears the flag by writing 1 to it. The interrupt line is that flag gated by an unmask bit. With the interrupt masked and an all-ones reload, the counter serves as a free-running time base. Software reads the inverse of the low count word to get a count that rises.

A parameter places the control register at one of two offsets. This lets the same block fit either register layout.

Top module: `evt_timer`

## Requirements
- R1: After reset, every register reads zero and `irq` is low.
- R2: The reload low word is at offset 0x00 and the high word is at 0x04, and both read back what was written. The count low word is at 0x08, the count high word at 0x0C, and the status word at 0x18. Any other offset reads zero.
- R3: The control register sits at offset `CTRL_OFS`, which is 0x10 by default or 0x1C as the alternative. Bit 0 enables, bit 1 selects one-shot (1) or periodic (0), and bit 2 unmasks the interrupt. The three bits read back in bits 2:0.
- R4: A control write that takes bit 0 from 0 to 1 loads the 64-bit counter from the reload value at that edge. The counter then drops by one per clock, with a borrow from the low word into the high word.
- R5: In periodic mode with reload N, a zero event occurs every N+1 clocks. At each zero event the flag is set and the counter is reloaded with N.
- R6: In one-shot mode the counter stops at zero after a single zero event. It stays at zero with no further events until enable rises again.
- R7: `irq` is high while the pending flag and the unmask bit are both set. Masking does not stop the flag from being set.
- R8: Writing 1 to status bit 0 clears the pending flag. Writing 0 to that bit leaves the flag unchanged.
- R9: When a clear write and a zero event fall on the same edge, the flag ends up set.
- R10: A control write with bit 0 at 0 stops the counter at its current value. A later rising enable reloads the counter.
- R11: A control write that keeps bit 0 at 1 does not reload the counter, and counting goes on without a gap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock; the counter also runs on it |
| rst_n | input | 1 | Active-low asynchronous reset |
| psel | input | 1 | Peripheral select |
| penable | input | 1 | Access phase strobe |
| pwrite | input | 1 | Write (1) or read (0) |
| paddr | input | ADDR_W | Byte address of the register |
| pwdata | input | 32 | Write data |
| prdata | output | 32 | Read data, combinational from `paddr` |
| irq | output | 1 | Level interrupt: pending flag gated by the unmask bit |

## Verification
The pending flag has two actions that can fall on the same clock edge: a zero event that sets it and a software write that clears it. The bench provokes this with a periodic reload of 3. It times the status write so that the access phase ends on the exact edge where the counter passes zero. It then reads the status word and expects 1. A second clear on an edge with no zero event must then read back 0.

// File: rtl/evt_timer.sv
module evt_timer #(
  parameter int          ADDR_W   = 8,
  parameter int unsigned CTRL_OFS = 'h10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              psel,
  input  logic              penable,
  input  logic              pwrite,
  input  logic [ADDR_W-1:0] paddr,
  input  logic [31:0]       pwdata,
  output logic [31:0]       prdata,
  output logic              irq
);
  localparam logic [ADDR_W-1:0] A_LDLO = ADDR_W'('h00);
  localparam logic [ADDR_W-1:0] A_LDHI = ADDR_W'('h04);
  localparam logic [ADDR_W-1:0] A_CVLO = ADDR_W'('h08);
  localparam logic [ADDR_W-1:0] A_CVHI = ADDR_W'('h0C);
  localparam logic [ADDR_W-1:0] A_STAT = ADDR_W'('h18);
  localparam logic [ADDR_W-1:0] A_CTRL = ADDR_W'(CTRL_OFS);

  logic [63:0] load_q, cnt_q;
  logic [2:0]  ctrl_q;
  logic        flag_q, hold_q;

  wire wr       = psel & penable & pwrite;
  wire wr_ctrl  = wr && (paddr == A_CTRL);
  wire en_rise  = wr_ctrl && pwdata[0] && !ctrl_q[0];
  wire step     = ctrl_q[0] && !(wr_ctrl && !pwdata[0]);
  wire zero_evt = step && (cnt_q == 64'd0) && (!ctrl_q[1] || !hold_q);
  wire clr      = wr && (paddr == A_STAT) && pwdata[0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      load_q <= '0;
      cnt_q  <= '0;
      ctrl_q <= '0;
      flag_q <= 1'b0;
      hold_q <= 1'b0;
    end else begin
      if (wr && paddr == A_LDLO) load_q[31:0]  <= pwdata;
      if (wr && paddr == A_LDHI) load_q[63:32] <= pwdata;
      if (wr_ctrl) ctrl_q <= pwdata[2:0];

      if (en_rise) begin
        cnt_q  <= load_q;
        hold_q <= 1'b0;
      end else if (step) begin
        if (cnt_q != 64'd0) cnt_q <= cnt_q - 64'd1;
        else if (!ctrl_q[1]) cnt_q <= load_q;
        if (zero_evt && ctrl_q[1]) hold_q <= 1'b1;
      end

      if (zero_evt) flag_q <= 1'b1;
      else if (clr) flag_q <= 1'b0;
    end
  end

  always_comb begin
    prdata = '0;
    if (paddr == A_LDLO)      prdata = load_q[31:0];
    else if (paddr == A_LDHI) prdata = load_q[63:32];
    else if (paddr == A_CVLO) prdata = cnt_q[31:0];
    else if (paddr == A_CVHI) prdata = cnt_q[63:32];
    else if (paddr == A_STAT) prdata = {31'd0, flag_q};
    else if (paddr == A_CTRL) prdata = {29'd0, ctrl_q};
  end

  assign irq = flag_q & ctrl_q[2];
endmodule

// File: rtl/evt_timer_chk.sv
module evt_timer_chk #(
  parameter int          ADDR_W   = 8,
  parameter int unsigned CTRL_OFS = 'h10
) (
  input logic              clk,
  input logic              rst_n,
  input logic              psel,
  input logic              penable,
  input logic              pwrite,
  input logic [ADDR_W-1:0] paddr,
  input logic [31:0]       pwdata,
  input logic              irq,
  input logic [63:0]       cnt,
  input logic [63:0]       load,
  input logic [2:0]        ctrl,
  input logic              flag
);
  logic bus_wr, c_wr, s_clr, idle_zero;
  assign bus_wr    = psel && penable && pwrite;
  assign c_wr      = bus_wr && (paddr == ADDR_W'(CTRL_OFS));
  assign s_clr     = bus_wr && (paddr == ADDR_W'('h18)) && pwdata[0];
  assign idle_zero = ctrl[0] && (cnt == 64'd0);

  a_r4_decrement: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl[0] && cnt != 64'd0 && !c_wr) |=> (cnt == $past(cnt) - 64'd1));

  a_r5_reload: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl[0] && !ctrl[1] && cnt == 64'd0 && !c_wr) |=> (cnt == $past(load)));

  a_r9_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl[0] && !ctrl[1] && cnt == 64'd0 && !c_wr) |=> flag);

  a_r6_stays_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl[0] && ctrl[1] && cnt == 64'd0 && !c_wr) |=> (cnt == 64'd0));

  a_r10_stopped: assert property (@(posedge clk) disable iff (!rst_n)
    (!ctrl[0] && !c_wr) |=> $stable(cnt));

  a_r8_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (s_clr && !idle_zero) |=> !flag);

  a_r7_irq_level: assert property (@(posedge clk) disable iff (!rst_n)
    (flag && ctrl[2] && !bus_wr) |=> irq);
endmodule

bind evt_timer evt_timer_chk #(.ADDR_W(ADDR_W), .CTRL_OFS(CTRL_OFS)) u_chk (
  .clk(clk), .rst_n(rst_n), .psel(psel), .penable(penable), .pwrite(pwrite),
  .paddr(paddr), .pwdata(pwdata), .irq(irq), .cnt(cnt_q), .load(load_q),
  .ctrl(ctrl_q), .flag(flag_q)
);

// File: tb/tb_evt_timer.sv
module tb_evt_timer;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic psel = 1'b0, penable = 1'b0, pwrite = 1'b0;
  logic [7:0] paddr = '0;
  logic [31:0] pwdata = '0;
  logic [31:0] prdata, prdata2;
  logic irq, irq2;
  int errors = 0, checks = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  evt_timer dut (.clk(clk), .rst_n(rst_n), .psel(psel), .penable(penable),
    .pwrite(pwrite), .paddr(paddr), .pwdata(pwdata), .prdata(prdata), .irq(irq));

  evt_timer #(.CTRL_OFS('h1C)) dut2 (.clk(clk), .rst_n(rst_n), .psel(psel),
    .penable(penable), .pwrite(pwrite), .paddr(paddr), .pwdata(pwdata),
    .prdata(prdata2), .irq(irq2));

  function automatic logic [31:0] oneshot_cnt(input int n, input int k);
    return (k >= n) ? 32'd0 : 32'(n - k);
  endfunction

  task automatic chk(input string tag, input logic [63:0] got, input logic [63:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %0h expected %0h", tag, got, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    psel = 1'b1; penable = 1'b0; pwrite = 1'b1; paddr = a; pwdata = d;
    @(negedge clk);
    penable = 1'b1;
    @(negedge clk);
    psel = 1'b0; penable = 1'b0; pwrite = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    psel = 1'b1; pwrite = 1'b0; paddr = a;
    #1 d = prdata;
    psel = 1'b0;
  endtask

  task automatic prog(input logic [31:0] lo, input logic [31:0] hi, input logic [2:0] c);
    wr(8'h10, 32'd0);
    wr(8'h18, 32'd1);
    wr(8'h00, lo);
    wr(8'h04, hi);
    wr(8'h10, {29'd0, c});
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [31:0] d, d2;
    void'($urandom(32'h5eed_1234));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    rd(8'h00, d); chk("R1 load lo", d, 0);
    rd(8'h08, d); chk("R1 count lo", d, 0);
    rd(8'h10, d); chk("R1 ctrl", d, 0);
    rd(8'h18, d); chk("R1 status", d, 0);
    chk("R1 irq", irq, 0);

    wr(8'h00, 32'hA5A5_1234); wr(8'h04, 32'h0000_BEEF);
    rd(8'h00, d); chk("R2 load lo readback", d, 32'hA5A5_1234);
    rd(8'h04, d); chk("R2 load hi readback", d, 32'h0000_BEEF);
    wr(8'h14, 32'hFFFF_FFFF);
    rd(8'h14, d); chk("R2 unmapped 0x14", d, 0);
    rd(8'h1C, d); chk("R2 unmapped 0x1C", d, 0);

    wr(8'h10, 32'hFFFF_FFF6);
    rd(8'h10, d); chk("R3 ctrl bits", d, 32'h6);
    wr(8'h1C, 32'h5);
    psel = 1'b1; paddr = 8'h1C; #1 d2 = prdata2; psel = 1'b0;
    chk("R3 alt ctrl offset", d2, 32'h5);
    psel = 1'b1; paddr = 8'h10; #1 d2 = prdata2; psel = 1'b0;
    chk("R3 alt variant 0x10 unmapped", d2, 0);
    wr(8'h1C, 32'h0);

    prog(32'h0, 32'h1, 3'b001);
    rd(8'h08, d); chk("R4 loaded lo", d, 0);
    rd(8'h0C, d); chk("R4 loaded hi", d, 1);
    @(negedge clk);
    rd(8'h08, d); chk("R4 borrow lo", d, 32'hFFFF_FFFF);
    rd(8'h0C, d); chk("R4 borrow hi", d, 0);

    prog(32'd5, 32'd0, 3'b101);
    repeat (5) @(negedge clk);
    rd(8'h08, d); chk("R5 at zero", d, 0);
    rd(8'h18, d); chk("R5 no event yet", d, 0);
    @(negedge clk);
    rd(8'h18, d); chk("R5 first event", d, 1);
    rd(8'h08, d); chk("R5 reloaded", d, 5);
    chk("R7 irq unmasked", irq, 1);
    wr(8'h18, 32'd0);
    rd(8'h18, d); chk("R8 write 0 keeps flag", d, 1);
    wr(8'h18, 32'd1);
    rd(8'h18, d); chk("R8 clear", d, 0);
    chk("R7 irq drops", irq, 0);
    repeat (1) @(negedge clk);
    rd(8'h18, d); chk("R5 period not yet", d, 0);
    @(negedge clk);
    rd(8'h18, d); chk("R5 second event after N+1", d, 1);

    prog(32'd3, 32'd0, 3'b101);
    repeat (6) @(negedge clk);
    wr(8'h18, 32'd1);
    rd(8'h18, d); chk("R9 set wins over clear", d, 1);
    wr(8'h18, 32'd1);
    rd(8'h18, d); chk("R9 later clear", d, 0);

    prog(32'd100, 32'd0, 3'b001);
    wr(8'h10, 32'h1);
    rd(8'h08, d); chk("R11 no reload on re-write", d, 98);
    repeat (8) @(negedge clk);
    wr(8'h10, 32'h0);
    rd(8'h08, d); chk("R10 stopped value", d, 89);
    repeat (7) @(negedge clk);
    rd(8'h08, d); chk("R10 still stopped", d, 89);
    wr(8'h10, 32'h1);
    rd(8'h08, d); chk("R10 re-enable reloads", d, 100);

    prog(32'd2, 32'd0, 3'b011);
    repeat (10) @(negedge clk);
    rd(8'h08, d); chk("R6 held at zero", d, 0);
    rd(8'h18, d); chk("R6 one event", d, 1);
    wr(8'h18, 32'd1);
    repeat (5) @(negedge clk);
    rd(8'h18, d); chk("R6 no second event", d, 0);
    chk("R7 masked irq low", irq, 0);

    for (int it = 0; it < 25; it++) begin
      int n, k;
      logic um;
      n  = 1 + int'($urandom % 40);
      k  = int'($urandom % (n + 1));
      um = 1'($urandom);
      prog(32'(n), 32'd0, {um, 2'b11});
      repeat (k) @(negedge clk);
      rd(8'h08, d); chk("R4 random count", d, oneshot_cnt(n, k));
      repeat (n + 2 - k) @(negedge clk);
      rd(8'h08, d); chk("R6 random end", d, 0);
      rd(8'h18, d); chk("R6 random flag", d, 1);
      chk("R7 random irq", irq, um);
    end

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule